// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, through a transceiver that can pass data in either direction. Each direction has a storage register with its own capture clock. A select input chooses whether that direction's outputs carry the live value from the opposite bus or the copy held in the register. Each direction also has its own output enable. The B-side enable is active high and the A-side enable is active low, so both directions can be switched on together. When both directions are on and both are in live mode, each bus is driven back with its own value and holds that value once every other source lets go.

The lanes are split into independent groups, two groups of eight by default. Each group has its own six control inputs. The block can therefore serve as several narrow transceivers or as one wide one. The pads are modelled as separate input, output and output-enable vectors per bus. The surrounding logic resolves the wired bus.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On a rising edge of a group's A-to-B capture clock, that group's A-to-B register takes the A input lanes of the group. On a rising edge of its B-to-A capture clock, the B-to-A register takes the B input lanes. Changes to the inputs between edges do not alter the stored data.
- R2: A capture happens on every rising capture edge, whatever the levels of the select and enable inputs, including while both output directions are disabled.
- R3: When the B side is enabled and its select is 0 (live), the B output lanes equal the current A input lanes, with no register stage in the path.
- R4: When the B side is enabled and its select is 1 (stored), the B output lanes equal the A-to-B register.
- R5: When the A side is enabled, the A output lanes equal the current B input lanes if the A-side select is 0, and the B-to-A register if it is 1.
- R6: The B-side enable is active high. At 1, all B output-enable lanes of the group are 1. At 0, they are 0 and the B output lanes read 0.
- R7: The A-side enable is active low. At 0, all A output-enable lanes of the group are 1. At 1, they are 0 and the A output lanes read 0.
- R8: Group g uses lanes g*GROUP_W up to g*GROUP_W+GROUP_W-1. Its controls and capture clocks affect no other group.
- R9: If the reset input is 1 at a rising capture edge, the register clocked by that edge is cleared to 0.
- R10: With both selects at 0 and both directions enabled, each bus output repeats its own bus. After the external driver is released, both buses keep their last value without contention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_i | input | 1 | Synchronous clear of the registers, sampled at each capture edge |
| cap_ab_clk_i | input | NUM_GROUPS | Per-group A-to-B capture clock |
| cap_ba_clk_i | input | NUM_GROUPS | Per-group B-to-A capture clock |
| sel_ab_i | input | NUM_GROUPS | Per-group B-output source: 0 live A, 1 stored |
| sel_ba_i | input | NUM_GROUPS | Per-group A-output source: 0 live B, 1 stored |
| drv_b_en_i | input | NUM_GROUPS | Per-group B-side drive enable, active high |
| drv_a_en_n_i | input | NUM_GROUPS | Per-group A-side drive enable, active low |
| a_in_i | input | NUM_GROUPS*GROUP_W | Value seen on the A bus |
| a_out_o | output | NUM_GROUPS*GROUP_W | Value driven onto the A bus |
| a_oe_o | output | NUM_GROUPS*GROUP_W | Per-lane A drive enable |
| b_in_i | input | NUM_GROUPS*GROUP_W | Value seen on the B bus |
| b_out_o | output | NUM_GROUPS*GROUP_W | Value driven onto the B bus |
| b_oe_o | output | NUM_GROUPS*GROUP_W | Per-lane B drive enable |

## Verification
Capture into a register and selection of the stored output can fall in the same cycle. In that case the output must show the value captured at the earlier edge, not the value being captured now. The bench provokes this by switching a group to stored mode and then clocking new data in while the output is disabled. It judges the result by enabling the output and comparing it against the earlier and later input values. Loop-back mode is the second overlap: both directions drive at once. The bench resolves both wired buses itself and counts every lane where an external driver and the block disagree.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        PATH_LIVE   = 1'b0,
        PATH_STORED = 1'b1
    } path_sel_e;

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.data = '0;
        end else begin
            st_d.data = d_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.data;

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             sel_i,
    input  logic             en_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] oe_o
);

    path_sel_e path;

    always_comb begin
        path  = path_sel_e'(sel_i);
        out_o = '0;
        if (en_i) begin
            out_o = (path == PATH_STORED) ? stored_i : live_i;
        end
        oe_o = {WIDTH{en_i}};
    end

endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
    parameter int WIDTH = 8
) (
    input  logic             rst_i,
    input  logic             clk_ab_i,
    input  logic             clk_ba_i,
    input  logic             sel_ab_i,
    input  logic             sel_ba_i,
    input  logic             en_b_i,
    input  logic             en_a_n_i,
    input  logic [WIDTH-1:0] a_in_i,
    input  logic [WIDTH-1:0] b_in_i,
    output logic [WIDTH-1:0] a_out_o,
    output logic [WIDTH-1:0] a_oe_o,
    output logic [WIDTH-1:0] b_out_o,
    output logic [WIDTH-1:0] b_oe_o
);

    logic [WIDTH-1:0] stored_ab;
    logic [WIDTH-1:0] stored_ba;
    logic             en_a;

    assign en_a = ~en_a_n_i;

    xcvr_store_reg #(.WIDTH(WIDTH)) i_reg_ab (
        .clk_i (clk_ab_i),
        .rst_i (rst_i),
        .d_i   (a_in_i),
        .q_o   (stored_ab)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) i_reg_ba (
        .clk_i (clk_ba_i),
        .rst_i (rst_i),
        .d_i   (b_in_i),
        .q_o   (stored_ba)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) i_mux_b (
        .sel_i    (sel_ab_i),
        .en_i     (en_b_i),
        .live_i   (a_in_i),
        .stored_i (stored_ab),
        .out_o    (b_out_o),
        .oe_o     (b_oe_o)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) i_mux_a (
        .sel_i    (sel_ba_i),
        .en_i     (en_a),
        .live_i   (b_in_i),
        .stored_i (stored_ba),
        .out_o    (a_out_o),
        .oe_o     (a_oe_o)
    );

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
    parameter  int NUM_GROUPS = 2,
    parameter  int GROUP_W    = 8,
    localparam int BUS_W      = NUM_GROUPS * GROUP_W
) (
    input  logic                  rst_i,
    input  logic [NUM_GROUPS-1:0] cap_ab_clk_i,
    input  logic [NUM_GROUPS-1:0] cap_ba_clk_i,
    input  logic [NUM_GROUPS-1:0] sel_ab_i,
    input  logic [NUM_GROUPS-1:0] sel_ba_i,
    input  logic [NUM_GROUPS-1:0] drv_b_en_i,
    input  logic [NUM_GROUPS-1:0] drv_a_en_n_i,
    input  logic [BUS_W-1:0]      a_in_i,
    output logic [BUS_W-1:0]      a_out_o,
    output logic [BUS_W-1:0]      a_oe_o,
    input  logic [BUS_W-1:0]      b_in_i,
    output logic [BUS_W-1:0]      b_out_o,
    output logic [BUS_W-1:0]      b_oe_o
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        xcvr_group #(.WIDTH(GROUP_W)) i_group (
            .rst_i    (rst_i),
            .clk_ab_i (cap_ab_clk_i[g]),
            .clk_ba_i (cap_ba_clk_i[g]),
            .sel_ab_i (sel_ab_i[g]),
            .sel_ba_i (sel_ba_i[g]),
            .en_b_i   (drv_b_en_i[g]),
            .en_a_n_i (drv_a_en_n_i[g]),
            .a_in_i   (a_in_i[g*GROUP_W +: GROUP_W]),
            .b_in_i   (b_in_i[g*GROUP_W +: GROUP_W]),
            .a_out_o  (a_out_o[g*GROUP_W +: GROUP_W]),
            .a_oe_o   (a_oe_o[g*GROUP_W +: GROUP_W]),
            .b_out_o  (b_out_o[g*GROUP_W +: GROUP_W]),
            .b_oe_o   (b_oe_o[g*GROUP_W +: GROUP_W])
        );
    end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter  int NUM_GROUPS = 2,
    parameter  int GROUP_W    = 8,
    localparam int BUS_W      = NUM_GROUPS * GROUP_W
) (
    input logic                  rst_i,
    input logic [NUM_GROUPS-1:0] cap_ab_clk_i,
    input logic [NUM_GROUPS-1:0] cap_ba_clk_i,
    input logic [NUM_GROUPS-1:0] sel_ab_i,
    input logic [NUM_GROUPS-1:0] sel_ba_i,
    input logic [NUM_GROUPS-1:0] drv_b_en_i,
    input logic [NUM_GROUPS-1:0] drv_a_en_n_i,
    input logic [BUS_W-1:0]      a_in_i,
    input logic [BUS_W-1:0]      a_out_o,
    input logic [BUS_W-1:0]      a_oe_o,
    input logic [BUS_W-1:0]      b_in_i,
    input logic [BUS_W-1:0]      b_out_o,
    input logic [BUS_W-1:0]      b_oe_o
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        logic armed_ab_q = 1'b0;
        logic armed_ba_q = 1'b0;

        always_ff @(posedge cap_ab_clk_i[g]) armed_ab_q <= ~rst_i;
        always_ff @(posedge cap_ba_clk_i[g]) armed_ba_q <= ~rst_i;

        AST_AB_STORED: assert property (@(posedge cap_ab_clk_i[g]) disable iff (rst_i)
            (armed_ab_q && sel_ab_i[g] && drv_b_en_i[g])
            |-> b_out_o[g*GROUP_W +: GROUP_W] == $past(a_in_i[g*GROUP_W +: GROUP_W])); // R4

        AST_BA_STORED: assert property (@(posedge cap_ba_clk_i[g]) disable iff (rst_i)
            (armed_ba_q && sel_ba_i[g] && !drv_a_en_n_i[g])
            |-> a_out_o[g*GROUP_W +: GROUP_W] == $past(b_in_i[g*GROUP_W +: GROUP_W])); // R5

        AST_B_LIVE: assert property (@(posedge cap_ab_clk_i[g]) disable iff (rst_i)
            (!sel_ab_i[g] && drv_b_en_i[g])
            |-> b_out_o[g*GROUP_W +: GROUP_W] == a_in_i[g*GROUP_W +: GROUP_W]); // R3

        AST_B_QUIET: assert property (@(posedge cap_ab_clk_i[g]) disable iff (rst_i)
            !drv_b_en_i[g]
            |-> (b_oe_o[g*GROUP_W +: GROUP_W] == '0) && (b_out_o[g*GROUP_W +: GROUP_W] == '0)); // R6

        AST_A_QUIET: assert property (@(posedge cap_ba_clk_i[g]) disable iff (rst_i)
            drv_a_en_n_i[g]
            |-> (a_oe_o[g*GROUP_W +: GROUP_W] == '0) && (a_out_o[g*GROUP_W +: GROUP_W] == '0)); // R7

        AST_LOOP_ECHO: assert property (@(posedge cap_ab_clk_i[g]) disable iff (rst_i)
            (!sel_ab_i[g] && !sel_ba_i[g] && drv_b_en_i[g] && !drv_a_en_n_i[g])
            |-> (b_out_o[g*GROUP_W +: GROUP_W] == a_in_i[g*GROUP_W +: GROUP_W])
             && (a_out_o[g*GROUP_W +: GROUP_W] == b_in_i[g*GROUP_W +: GROUP_W])); // R10
    end

endmodule

bind reg_bus_xcvr xcvr_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) i_xcvr_checker (.*);

// File: tb/test_reg_bus_xcvr.sv
`timescale 1ns/1ps
module test_reg_bus_xcvr;

    localparam int NG = 2;
    localparam int GW = 8;
    localparam int BW = NG * GW;

    // source codes: 0 off, 1 opposite bus external, 2 A-to-B store, 3 B-to-A store, 4 skip
    // row layout: {sab, sba, oeab, oeba_n, exp_b_oe, exp_a_oe, b_src[2:0], a_src[2:0]}
    localparam logic [11:0] VEC [16] = '{
        {4'd0,  1'b0, 1'b1, 3'd0, 3'd1},
        {4'd1,  1'b0, 1'b0, 3'd0, 3'd0},
        {4'd2,  1'b1, 1'b1, 3'd4, 3'd4},
        {4'd3,  1'b1, 1'b0, 3'd1, 3'd0},
        {4'd4,  1'b0, 1'b1, 3'd0, 3'd3},
        {4'd5,  1'b0, 1'b0, 3'd0, 3'd0},
        {4'd6,  1'b1, 1'b1, 3'd3, 3'd3},
        {4'd7,  1'b1, 1'b0, 3'd1, 3'd0},
        {4'd8,  1'b0, 1'b1, 3'd0, 3'd1},
        {4'd9,  1'b0, 1'b0, 3'd0, 3'd0},
        {4'd10, 1'b1, 1'b1, 3'd2, 3'd2},
        {4'd11, 1'b1, 1'b0, 3'd2, 3'd0},
        {4'd12, 1'b0, 1'b1, 3'd0, 3'd3},
        {4'd13, 1'b0, 1'b0, 3'd0, 3'd0},
        {4'd14, 1'b1, 1'b1, 3'd2, 3'd3},
        {4'd15, 1'b1, 1'b0, 3'd2, 3'd0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic [NG-1:0] cap_ab, cap_ba, sab, sba, oeab, oeba_n;
    logic [BW-1:0] ext_a, ext_b, ext_a_en, ext_b_en;
    logic [BW-1:0] a_bus, b_bus, a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    int contention = 0;

    reg_bus_xcvr #(.NUM_GROUPS(NG), .GROUP_W(GW)) i_reg_bus_xcvr (
        .rst_i        (rst),
        .cap_ab_clk_i (cap_ab),
        .cap_ba_clk_i (cap_ba),
        .sel_ab_i     (sab),
        .sel_ba_i     (sba),
        .drv_b_en_i   (oeab),
        .drv_a_en_n_i (oeba_n),
        .a_in_i       (a_bus),
        .a_out_o      (a_out),
        .a_oe_o       (a_oe),
        .b_in_i       (b_bus),
        .b_out_o      (b_out),
        .b_oe_o       (b_oe)
    );

    // wired-bus resolution: external driver wins when enabled, otherwise the block, otherwise 0
    always_comb begin
        for (int k = 0; k < BW; k++) begin
            a_bus[k] = ext_a_en[k] ? ext_a[k] : (a_oe[k] ? a_out[k] : 1'b0);
            b_bus[k] = ext_b_en[k] ? ext_b[k] : (b_oe[k] ? b_out[k] : 1'b0);
        end
    end

    always @(posedge clk) begin
        if (!rst && (((ext_a_en & a_oe & (ext_a ^ a_out)) != '0) ||
                     ((ext_b_en & b_oe & (ext_b ^ b_out)) != '0)))
            contention++;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply control nibble {sab, sba, oeab, oeba_n} to group g; external drivers fill the idle sides
    task automatic set_ctrl(int g, logic [3:0] c);
        sab[g]    = c[3];
        sba[g]    = c[2];
        oeab[g]   = c[1];
        oeba_n[g] = c[0];
        ext_a_en[g*GW +: GW] = {GW{c[0]}};
        ext_b_en[g*GW +: GW] = {GW{~c[1]}};
    endtask

    task automatic pulse(logic [NG-1:0] ab, logic [NG-1:0] ba);
        @(negedge clk);
        cap_ab = ab;
        cap_ba = ba;
        @(negedge clk);
        cap_ab = '0;
        cap_ba = '0;
    endtask

    function automatic logic [GW-1:0] src_val(logic [2:0] code, logic [GW-1:0] opp,
                                              logic [GW-1:0] st_ab, logic [GW-1:0] st_ba);
        case (code)
            3'd1:    return opp;
            3'd2:    return st_ab;
            3'd3:    return st_ba;
            default: return '0;
        endcase
    endfunction

    logic [GW-1:0] st_ab [NG];
    logic [GW-1:0] st_ba [NG];

    initial begin
        rst = 1'b1;
        cap_ab = '0; cap_ba = '0;
        ext_a = '0; ext_b = '0;
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b0001);
        repeat (2) @(negedge clk);

        // R9: reset clears both registers
        pulse('1, '1);
        @(negedge clk);
        rst = 1'b0;
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1110);
        @(posedge clk);
        check("R9 reset B out", 32'(b_out), 32'h0);
        check("R9 reset A out", 32'(a_out), 32'h0);
        check("R6 reset B oe", 32'(b_oe), 32'hFFFF);
        check("R7 reset A oe", 32'(a_oe), 32'hFFFF);

        // load stores with all outputs off
        @(negedge clk);
        st_ab[0] = 8'h3C; st_ba[0] = 8'hA5;
        st_ab[1] = 8'h96; st_ba[1] = 8'h0F;
        for (int g = 0; g < NG; g++) begin
            set_ctrl(g, 4'b0001);
            ext_a[g*GW +: GW] = st_ab[g];
            ext_b[g*GW +: GW] = st_ba[g];
        end
        pulse('1, '1);

        // table walk: group 0 takes row i, group 1 takes row 15-i
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            for (int g = 0; g < NG; g++) begin
                int r = (g == 0) ? i : 15 - i;
                logic [GW-1:0] pat = (8'h11 * r[7:0]) ^ 8'h42;
                set_ctrl(g, VEC[r][11:8]);
                ext_a[g*GW +: GW] = pat;
                ext_b[g*GW +: GW] = ~pat;
            end
            @(posedge clk);
            for (int g = 0; g < NG; g++) begin
                int r = (g == 0) ? i : 15 - i;
                logic [11:0]   v = VEC[r];
                logic [GW-1:0] pat = (8'h11 * r[7:0]) ^ 8'h42;
                check("R6 B oe table", 32'(b_oe[g*GW +: GW]), 32'({GW{v[7]}}));
                check("R7 A oe table", 32'(a_oe[g*GW +: GW]), 32'({GW{v[6]}}));
                if (v[5:3] != 3'd4)
                    check(v[5:3] == 3'd0 ? "R6 B off" : v[5:3] == 3'd1 ? "R3 B live" : "R4 B stored",
                          32'(b_out[g*GW +: GW]), 32'(src_val(v[5:3], pat, st_ab[g], st_ba[g])));
                if (v[2:0] != 3'd4)
                    check(v[2:0] == 3'd0 ? "R7 A off" : "R5 A path",
                          32'(a_out[g*GW +: GW]), 32'(src_val(v[2:0], ~pat, st_ab[g], st_ba[g])));
            end
        end

        // R2 + R1: capture while disabled and stored-selected, then change inputs after the edge
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1101);
        ext_a = 16'h1234;
        ext_b = 16'hBEEF;
        pulse('1, '1);
        @(negedge clk);
        ext_a = 16'hFFFF;
        ext_b = 16'h0000;
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1110);
        @(posedge clk);
        check("R2 B stored after disabled capture", 32'(b_out), 32'h1234);
        check("R2 A stored after disabled capture", 32'(a_out), 32'hBEEF);

        // R8: clock only group 0 A-to-B
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1101);
        ext_a = 16'h5555;
        pulse(2'b01, 2'b00);
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1110);
        @(posedge clk);
        check("R8 group isolation B", 32'(b_out), 32'h1255);
        check("R8 group isolation A", 32'(a_out), 32'hBEEF);
        check("R1 edge-only capture", 32'(b_out[15:8]), 32'h12);

        // R10: loop-back hold
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b0011);
        ext_a = 16'hC3A7;
        @(posedge clk);
        check("R3 live A to B", 32'(b_out), 32'hC3A7);
        @(negedge clk);
        oeba_n = '0;
        @(negedge clk);
        ext_a_en = '0;
        @(posedge clk);
        check("R10 A bus holds", 32'(a_bus), 32'hC3A7);
        check("R10 B bus holds", 32'(b_bus), 32'hC3A7);
        check("R10 echo A out", 32'(a_out), 32'hC3A7);
        check("R10 no contention", 32'(contention), 32'h0);

        // R9: reset again with nonzero stores
        @(negedge clk);
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1101);
        rst = 1'b1;
        pulse('1, '1);
        @(negedge clk);
        rst = 1'b0;
        for (int g = 0; g < NG; g++) set_ctrl(g, 4'b1110);
        @(posedge clk);
        check("R9 second reset B", 32'(b_out), 32'h0);
        check("R9 second reset A", 32'(a_out), 32'h0);

        finish_run();
    end

endmodule